// File: doc/BRIEF.md
# Fixed-Point to 12-Bit Minifloat Encoder

This block turns a signed two's complement fixed-point sample into a compact 12-bit floating-point word. The word has one sign bit, a 4-bit exponent stored with an offset of 7, and a 7-bit fraction that follows an implied leading one. The binary point sits just after that implied one.

The magnitude of the input is normalized with a leading-one search. Fraction bits that do not fit are cut off, and a flag reports when any of the cut bits was nonzero. Very small magnitudes fall to the non-normalized range, where the exponent field is zero. Magnitudes too large for the widest exponent saturate to infinity.

The input side takes a sample on any cycle where the valid strobe is high, because the block is always ready. The result is registered and appears one clock later. It then stays on the outputs until the next sample is taken.

Top module: `minif_encoder`

## Requirements
- R1: The output word is laid out as bit 11 sign, bits 10..7 exponent, bits 6..0 fraction. A magnitude of 1.f × 2^e with -6 ≤ e ≤ 7 carries exponent code e+7 and the seven bits of f. For example, 1.75 → 0x3E0, 17.5 → 0x58C and 175.0 → 0x72F.
- R2: A negative input sets bit 11 and encodes its magnitude in bits 10..0, so -1.75 → 0xBE0. The most negative input is encoded by its full magnitude.
- R3: A zero input yields the word 0x000 with the inexact flag low.
- R4: A magnitude of 256.0 or more yields exponent 1111 with fraction 0000000, keeping the sign, and raises the inexact flag.
- R5: A nonzero magnitude below 2^-6 yields exponent 0000 and a fraction equal to the magnitude × 2^13. For example, 2^-8 → 0x020 and 3×2^-8 → 0x060. The inexact flag stays low.
- R6: Fraction bits below the 7 kept bits are dropped, never rounded. The inexact flag is high exactly when a dropped bit was 1. For example, 255.99609375 → 0x77F with the flag high, and 1.0 + 2^-8 → 0x380 with the flag high.
- R7: in_ready is always high. A sample accepted at a clock edge shows its result on the next edge with out_valid high. Outputs stay unchanged while no new sample is accepted.
- R8: During and right after reset, out_valid, out_word and out_inexact are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_ready | output | 1 | Always high |
| in_data | input | IN_W (24) | Two's complement input, FRAC_W (8) fraction bits |
| out_valid | output | 1 | Registered result valid |
| out_word | output | 12 | Encoded minifloat word |
| out_inexact | output | 1 | High when nonzero bits were dropped or the value saturated |

## Verification
The bench builds the block with IN_W = 24 and FRAC_W = 8. These values make every part of the code space reachable from the input. The largest magnitudes pass 2^8, so saturation to infinity can be driven. The smallest step, 2^-8, lies below the normal floor of 2^-6, so three input codes fall into the non-normalized range. The whole exponent range from code 0001 to code 1110 is covered, including the most negative input, whose magnitude needs the full word width.

// File: rtl/minif_pkg.sv
package minif_pkg;

  localparam int MF_EXP_W = 4;
  localparam int MF_MAN_W = 7;
  localparam int MF_BIAS  = (1 << (MF_EXP_W - 1)) - 1;

  typedef struct packed {
    logic                sign;
    logic [MF_EXP_W-1:0] exp;
    logic [MF_MAN_W-1:0] man;
  } minif_t;

  // Exponent code for a leading one at bit position pos of a value with frac fraction bits.
  function automatic int exp_code(input int pos, input int frac);
    return pos - frac + MF_BIAS;
  endfunction

  // Left shift that moves a non-normalized magnitude onto the 2^-(bias-1+man) grid.
  function automatic int denorm_shift(input int frac);
    return MF_BIAS - 1 + MF_MAN_W - frac;
  endfunction

endpackage

// File: rtl/minif_magnitude.sv
module minif_magnitude #(
  parameter int W = 24
) (
  input  logic [W-1:0] data,
  output logic         neg,
  output logic [W-1:0] mag
);
  // Two's complement absolute value; the most negative code maps to 2^(W-1) unsigned.
  assign neg = data[W-1];
  assign mag = neg ? (~data + W'(1)) : data;
endmodule

// File: rtl/minif_lead_one.sv
module minif_lead_one #(
  parameter int W  = 24,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/minif_pack.sv
module minif_pack
  import minif_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 8,
  localparam int PW    = $clog2(IN_W)
) (
  input  logic            neg,
  input  logic [IN_W-1:0] mag,
  input  logic [PW-1:0]   pos,
  input  logic            found,
  output minif_t          word,
  output logic            inexact,
  output logic            ev_zero,
  output logic            ev_denorm,
  output logic            ev_ovf
);
  localparam int NORM_MIN_POS = FRAC_W + 1 - MF_BIAS;
  localparam int OVF_POS      = FRAC_W + MF_BIAS + 1;
  localparam int DEN_SH       = denorm_shift(FRAC_W);
  localparam int LOW_W        = IN_W - 1 - MF_MAN_W;

  logic [PW-1:0]       shamt;
  logic [IN_W-2:0]     norm;
  logic [MF_MAN_W-1:0] norm_man;
  logic                norm_sticky;
  logic [MF_EXP_W-1:0] norm_exp;
  logic [MF_MAN_W-1:0] den_man;

  assign shamt       = PW'(IN_W - 1) - pos;
  assign norm        = (IN_W-1)'(mag << shamt);
  assign norm_man    = norm[IN_W-2 -: MF_MAN_W];
  assign norm_sticky = |norm[LOW_W-1:0];
  assign norm_exp    = MF_EXP_W'(exp_code(int'(pos), FRAC_W));
  assign den_man     = MF_MAN_W'(mag << DEN_SH);

  assign ev_zero   = !found;
  assign ev_ovf    = found && (int'(pos) >= OVF_POS);
  assign ev_denorm = found && (int'(pos) < NORM_MIN_POS);

  always_comb begin
    word.sign = neg;
    if (ev_zero) begin
      word.exp = '0;
      word.man = '0;
      inexact  = 1'b0;
    end else if (ev_ovf) begin
      word.exp = '1;
      word.man = '0;
      inexact  = 1'b1;
    end else if (ev_denorm) begin
      word.exp = '0;
      word.man = den_man;
      inexact  = 1'b0;
    end else begin
      word.exp = norm_exp;
      word.man = norm_man;
      inexact  = norm_sticky;
    end
  end
endmodule

// File: rtl/minif_encoder.sv
module minif_encoder
  import minif_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 8,
  localparam int PW    = $clog2(IN_W),
  localparam int OUT_W = 1 + MF_EXP_W + MF_MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word,
  output logic             out_inexact
);
  logic            neg;
  logic [IN_W-1:0] mag;
  logic [PW-1:0]   pos;
  logic            found;
  minif_t          word_d;
  logic            inexact_d;
  logic            ev_zero, ev_denorm, ev_ovf;
  logic            accept;

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  minif_magnitude #(.W(IN_W)) u_mag (
    .data(in_data), .neg(neg), .mag(mag)
  );

  minif_lead_one #(.W(IN_W)) u_lead (
    .vec(mag), .pos(pos), .found(found)
  );

  minif_pack #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_pack (
    .neg(neg), .mag(mag), .pos(pos), .found(found),
    .word(word_d), .inexact(inexact_d),
    .ev_zero(ev_zero), .ev_denorm(ev_denorm), .ev_ovf(ev_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_inexact <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_word    <= word_d;
      out_inexact <= inexact_d;
    end
  end

  // R7: a result follows every accepted sample on the next edge
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R7: outputs hold while nothing new is accepted
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !accept) |=> (out_valid && $stable(out_word) && $stable(out_inexact)));

  // R2: sign bit of the result tracks the sign of the accepted sample
  assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_word[OUT_W-1] == $past(in_data[IN_W-1])));

  // R3: zero input gives the all-zero word and no inexact flag
  assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ev_zero) |=> (out_word == '0 && !out_inexact));

  // R4: saturation gives infinity with an empty fraction and the flag set
  assert_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ev_ovf) |=> (out_word[OUT_W-2 -: MF_EXP_W] == '1 &&
                            out_word[MF_MAN_W-1:0] == '0 && out_inexact));

  // R5: non-normalized results are always exact
  assert_denorm_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ev_denorm) |=> (out_word[OUT_W-2 -: MF_EXP_W] == '0 && !out_inexact));

  // R8: nothing is valid in the cycle after reset
  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_word == '0));
endmodule

// File: tb/minif_encoder_bench.sv
module minif_encoder_bench;
  localparam int IN_W   = 24;
  localparam int FRAC_W = 8;

  typedef struct {
    logic [11:0] w;
    logic        x;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic            in_ready;
  logic            out_valid;
  logic [11:0]     out_word;
  logic            out_inexact;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic acc = 1'b0;
  exp_t q[$];
  exp_t last;

  always #5 clk = ~clk;

  minif_encoder #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_minif_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_word(out_word),
    .out_inexact(out_inexact)
  );

  // Reference encoding: searches the exponent by range comparison and divides.
  function automatic exp_t model(input longint v);
    exp_t   r;
    longint m;
    longint lo;
    r.x = 1'b0;
    m   = (v < 0) ? -v : v;
    r.w = {(v < 0), 11'd0};
    if (m == 0) begin
      r.w = 12'h000;
    end else if (m >= 65536) begin
      r.w[10:7] = 4'hF;
      r.x       = 1'b1;
    end else if (m < 4) begin
      r.w[6:0] = 7'(m * 32);
    end else begin
      for (int e = -6; e <= 7; e++) begin
        lo = longint'(1) << (e + 8);
        if (m >= lo && m < 2 * lo) begin
          r.w[10:7] = 4'(e + 7);
          r.w[6:0]  = 7'((m * 128) / lo - 128);
          r.x       = ((m * 128) % lo) != 0;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic send_exp(input logic [IN_W-1:0] v, input logic [11:0] w,
                          input logic x, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    e.w = w; e.x = x; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic [IN_W-1:0] v, input string tag);
    exp_t e;
    e = model(longint'($signed(v)));
    send_exp(v, e.w, e.x, tag);
  endtask

  task automatic idle(input int n, input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      check(out_valid && out_word == last.w && out_inexact == last.x, tag, "hold",
            {19'd0, out_valid, out_word}, {19'd0, 1'b1, last.w});
    end
  endtask

  // Scoreboard monitor
  always @(posedge clk) acc <= rst_n && in_valid;

  always @(negedge clk) begin
    exp_t e;
    if (acc) begin
      if (q.size() == 0) begin
        check(1'b0, "R7", "unexpected result", {20'd0, out_word}, 32'd0);
      end else begin
        e = q.pop_front();
        last = e;
        check(out_valid == 1'b1, "R7", "valid", {31'd0, out_valid}, 32'd1);
        check(out_word == e.w, e.tag, "word", {20'd0, out_word}, {20'd0, e.w});
        check(out_inexact == e.x, e.tag, "inexact", {31'd0, out_inexact}, {31'd0, e.x});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && out_word == 12'h000 && !out_inexact, "R8", "reset outputs",
          {19'd0, out_valid, out_word}, 32'd0);
    check(in_ready == 1'b1, "R7", "ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R8", "valid after reset", {31'd0, out_valid}, 32'd0);

    // R1: worked examples, fixed expectations
    send_exp(24'd448,   12'h3E0, 1'b0, "R1");
    send_exp(24'd4480,  12'h58C, 1'b0, "R1");
    send_exp(24'd44800, 12'h72F, 1'b0, "R1");
    send_exp(24'd256,   12'h380, 1'b0, "R1");
    send_exp(24'd4,     12'h080, 1'b0, "R1");
    idle(3, "R7");
    // R2: negatives
    send_exp(-24'sd448, 12'hBE0, 1'b0, "R2");
    send_exp(24'h800000, 12'hF80, 1'b1, "R2");
    send_exp(-24'sd4480, 12'hD8C, 1'b0, "R2");
    // R3: zero
    send_exp(24'd0, 12'h000, 1'b0, "R3");
    idle(2, "R7");
    // R4: overflow boundary
    send_exp(24'd65536,   12'h780, 1'b1, "R4");
    send_exp(-24'sd65536, 12'hF80, 1'b1, "R4");
    send_exp(24'h7FFFFF,  12'h780, 1'b1, "R4");
    // R5: non-normalized
    send_exp(24'd1, 12'h020, 1'b0, "R5");
    send_exp(24'd2, 12'h040, 1'b0, "R5");
    send_exp(24'd3, 12'h060, 1'b0, "R5");
    send_exp(-24'sd3, 12'h860, 1'b0, "R5");
    send_exp(24'd5, 12'h0A0, 1'b0, "R5");
    // R6: truncation and inexact
    send_exp(24'd65535, 12'h77F, 1'b1, "R6");
    send_exp(24'd257,   12'h380, 1'b1, "R6");
    send_exp(24'd511,   12'h3FF, 1'b1, "R6");
    send_exp(24'd510,   12'h3FF, 1'b0, "R6");
    idle(4, "R7");
    // R1/R6: sweep of mixed patterns against the reference
    for (int i = 1; i < 60; i++) begin
      logic [63:0] h;
      logic [IN_W-1:0] v;
      h = 64'(i) * 64'd2654435761;
      v = h[IN_W-1:0] >> (i % 23);
      if (i % 2 == 1) v = -v;
      send(v, "R6");
      if (i % 9 == 0) idle(1, "R7");
    end
    idle(2, "R7");
    // R8: reset mid-stream clears the outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && out_word == 12'h000 && !out_inexact, "R8", "second reset",
          {19'd0, out_valid, out_word}, 32'd0);
    rst_n = 1'b1;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule